// File: doc/BRIEF.md
# Windowed Register File with Call/Return Window Pointer

This block is a register file whose instructions see 32 register names, while the storage behind them is much larger. A current window pointer picks which slice of that storage the names refer to. Names 0 to 7 always reach one shared group of global registers. The other 24 names reach the window selected by the pointer.

Neighbouring windows share storage. The registers a caller fills with outgoing arguments are the same storage the callee reads as incoming arguments, so no copy is made in either direction. A call command moves the pointer forward by one and a return command moves it back by one, both wrapping around the ring of windows.

Each window can be marked as spilled in an input mask. A call or return whose target window is marked raises an overflow or underflow flag in that same cycle and leaves the pointer unchanged. Software then saves or restores windows in memory and clears the mark. The file has two combinational read ports and one write port that takes effect at the clock edge.

Top module: `rwin_regfile`

## Requirements
- R1: After reset, the window pointer is 0, both flags are low and every register name reads zero.
- R2: Names 0 to 7 reach the same eight global registers whatever the window pointer holds.
- R3: In window w, names 8 to 15 form that window's outgoing-argument group and names 16 to 23 its local group. The local group of one window is never visible from another window.
- R4: With a call and no return, the pointer becomes (w+1) mod 8 at the next edge. With a return and no call, it becomes (w+7) mod 8. This covers the wraps 7 to 0 and 0 to 7, provided the target window is not marked.
- R5: Name 24+k in window w+1 is the same storage as name 8+k in window w, for k from 0 to 7. Values written on either side are seen on the other after a call or a return.
- R6: A call whose target window (w+1) mod 8 has its bit set in the spilled mask raises overflow in that cycle, and the pointer keeps its value.
- R7: A return whose target window (w+7) mod 8 has its bit set in the spilled mask raises underflow in that cycle, and the pointer keeps its value.
- R8: When call and return are asserted together, the pointer keeps its value and neither flag is raised.
- R9: Reads are combinational and a write lands at the rising clock edge. A read of the name being written in the same cycle returns the new data (write-through).
- R10: A write issued in the same cycle as a call or a return goes to the window that was current before the pointer moves.
- R11: Both flags stay low in any cycle without a call or return command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Call command: advance the window pointer |
| ret_i | input | 1 | Return command: move the window pointer back |
| win_invalid_i | input | NWIN | Spilled-window mask, one bit per window |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | 5 | Register name to write |
| wr_data_i | input | DW | Write data |
| rd_a_idx_i | input | 5 | Register name, read port A |
| rd_a_data_o | output | DW | Read data, port A |
| rd_b_idx_i | input | 5 | Register name, read port B |
| rd_b_data_o | output | DW | Read data, port B |
| cwp_o | output | $clog2(NWIN) | Current window pointer |
| overflow_o | output | 1 | Call target window is spilled |
| underflow_o | output | 1 | Return target window is spilled |

## Verification
A write and a window move can fall in the same cycle. So can a write and a read of the same name. The bench issues a write to a local or argument name together with a call or a return, and later reads that name back from the original window, which shows the write used the old pointer. It also reads every name in the same cycle as its write, where the new data must appear at once. A behavioural model built from per-window argument and local arrays predicts both read ports, both flags and the pointer on every clock. Pseudo-random call, return, write and mask patterns are compared against it alongside the directed cases.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
  // architectural layout: four groups of eight names
  localparam int unsigned GRP  = 8;
  localparam int unsigned NAMES = 32;
  localparam int unsigned IDXW = 5;

  typedef enum logic [1:0] {
    G_GLOBAL = 2'd0,
    G_OUTARG = 2'd1,
    G_LOCAL  = 2'd2,
    G_INARG  = 2'd3
  } name_grp_e;

  function automatic name_grp_e group_of(input logic [IDXW-1:0] idx);
    return name_grp_e'(idx[4:3]);
  endfunction
endpackage

// File: rtl/rwin_map.sv
module rwin_map
  import rwin_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned CW   = 3,
  parameter int unsigned PW   = 8
) (
  input  logic [IDXW-1:0] idx_i,
  input  logic [CW-1:0]   cwp_i,
  output logic [PW-1:0]   phys_o
);
  localparam int unsigned SPAN = 2 * GRP;

  logic [CW-1:0] prev_win;
  logic [PW-1:0] off;
  logic [PW-1:0] own_base;
  logic [PW-1:0] prev_base;

  always_comb begin
    prev_win  = (cwp_i == '0) ? CW'(NWIN - 1) : cwp_i - 1'b1;
    off       = PW'(idx_i[2:0]);
    own_base  = PW'(GRP) + PW'(cwp_i) * PW'(SPAN);
    prev_base = PW'(GRP) + PW'(prev_win) * PW'(SPAN);
    case (group_of(idx_i))
      G_GLOBAL: phys_o = off;
      G_OUTARG: phys_o = own_base + off;
      G_LOCAL:  phys_o = own_base + PW'(GRP) + off;
      default:  phys_o = prev_base + off;
    endcase
  end
endmodule

// File: rtl/rwin_ctrl.sv
module rwin_ctrl #(
  parameter int unsigned NWIN = 8,
  parameter int unsigned CW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            call_i,
  input  logic            ret_i,
  input  logic [NWIN-1:0] invalid_i,
  output logic [CW-1:0]   cwp_o,
  output logic            ovf_o,
  output logic            unf_o
);
  logic [CW-1:0] cwp_q;
  logic [CW-1:0] fwd_win;
  logic [CW-1:0] back_win;
  logic          do_call;
  logic          do_ret;

  always_comb begin
    fwd_win  = (cwp_q == CW'(NWIN - 1)) ? '0 : cwp_q + 1'b1;
    back_win = (cwp_q == '0) ? CW'(NWIN - 1) : cwp_q - 1'b1;
    do_call  = call_i && !ret_i;
    do_ret   = ret_i && !call_i;
    ovf_o    = do_call && invalid_i[fwd_win];
    unf_o    = do_ret && invalid_i[back_win];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp_q <= '0;
    end else if (do_call && !ovf_o) begin
      cwp_q <= fwd_win;
    end else if (do_ret && !unf_o) begin
      cwp_q <= back_win;
    end
  end

  assign cwp_o = cwp_q;
endmodule

// File: rtl/rwin_store.sv
module rwin_store #(
  parameter int unsigned NPHYS = 136,
  parameter int unsigned PW    = 8,
  parameter int unsigned DW    = 32,
  parameter int unsigned NRD   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we_i,
  input  logic [PW-1:0]           waddr_i,
  input  logic [DW-1:0]           wdata_i,
  input  logic [NRD-1:0][PW-1:0]  raddr_i,
  output logic [NRD-1:0][DW-1:0]  rdata_o
);
  logic [DW-1:0] cells [NPHYS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) cells[i] <= '0;
    end else if (we_i) begin
      cells[waddr_i] <= wdata_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic hit;
    assign hit        = we_i && (waddr_i == raddr_i[p]);
    assign rdata_o[p] = hit ? wdata_i : cells[raddr_i[p]];
  end
endmodule

// File: rtl/rwin_regfile.sv
module rwin_regfile
  import rwin_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned DW   = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    call_i,
  input  logic                    ret_i,
  input  logic [NWIN-1:0]         win_invalid_i,
  input  logic                    wr_en_i,
  input  logic [4:0]              wr_idx_i,
  input  logic [DW-1:0]           wr_data_i,
  input  logic [4:0]              rd_a_idx_i,
  output logic [DW-1:0]           rd_a_data_o,
  input  logic [4:0]              rd_b_idx_i,
  output logic [DW-1:0]           rd_b_data_o,
  output logic [$clog2(NWIN)-1:0] cwp_o,
  output logic                    overflow_o,
  output logic                    underflow_o
);
  localparam int unsigned CW    = $clog2(NWIN);
  localparam int unsigned NPHYS = GRP + 2 * GRP * NWIN;
  localparam int unsigned PW    = $clog2(NPHYS);
  localparam int unsigned NRD   = 2;
  localparam int unsigned NMAP  = NRD + 1;

  logic [CW-1:0]                cwp;
  logic [NMAP-1:0][IDXW-1:0]    names;
  logic [NMAP-1:0][PW-1:0]      phys;
  logic [NRD-1:0][PW-1:0]       rd_phys;
  logic [NRD-1:0][DW-1:0]       rd_data;

  assign names[0] = rd_a_idx_i;
  assign names[1] = rd_b_idx_i;
  assign names[2] = wr_idx_i;

  rwin_ctrl #(.NWIN(NWIN), .CW(CW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .call_i    (call_i),
    .ret_i     (ret_i),
    .invalid_i (win_invalid_i),
    .cwp_o     (cwp),
    .ovf_o     (overflow_o),
    .unf_o     (underflow_o)
  );

  for (genvar m = 0; m < NMAP; m++) begin : g_map
    rwin_map #(.NWIN(NWIN), .CW(CW), .PW(PW)) u_map (
      .idx_i  (names[m]),
      .cwp_i  (cwp),
      .phys_o (phys[m])
    );
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rdp
    assign rd_phys[r] = phys[r];
  end

  rwin_store #(.NPHYS(NPHYS), .PW(PW), .DW(DW), .NRD(NRD)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (wr_en_i),
    .waddr_i (phys[NRD]),
    .wdata_i (wr_data_i),
    .raddr_i (rd_phys),
    .rdata_o (rd_data)
  );

  assign rd_a_data_o = rd_data[0];
  assign rd_b_data_o = rd_data[1];
  assign cwp_o       = cwp;
endmodule

// File: rtl/rwin_regfile_chk.sv
module rwin_regfile_chk #(
  parameter int unsigned NWIN = 8,
  parameter int unsigned DW   = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    call_i,
  input logic                    ret_i,
  input logic [NWIN-1:0]         win_invalid_i,
  input logic                    wr_en_i,
  input logic [4:0]              wr_idx_i,
  input logic [DW-1:0]           wr_data_i,
  input logic [4:0]              rd_a_idx_i,
  input logic [DW-1:0]           rd_a_data_o,
  input logic [4:0]              rd_b_idx_i,
  input logic [DW-1:0]           rd_b_data_o,
  input logic [$clog2(NWIN)-1:0] cwp_o,
  input logic                    overflow_o,
  input logic                    underflow_o
);
  localparam int unsigned CW = $clog2(NWIN);

  a_r4_call_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && !ret_i && !overflow_o) |=>
      (cwp_o == (($past(cwp_o) == CW'(NWIN - 1)) ? '0 : $past(cwp_o) + 1'b1)));

  a_r4_ret_retreat: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !call_i && !underflow_o) |=>
      (cwp_o == (($past(cwp_o) == '0) ? CW'(NWIN - 1) : $past(cwp_o) - 1'b1)));

  a_r6_overflow_holds: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> $stable(cwp_o));

  a_r7_underflow_holds: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |=> $stable(cwp_o));

  a_r8_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && ret_i) |=> $stable(cwp_o));

  a_r8_both_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && ret_i) |-> (!overflow_o && !underflow_o));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!call_i && !ret_i) |-> (!overflow_o && !underflow_o));

  a_r9_bypass_a: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_idx_i == rd_a_idx_i) |-> (rd_a_data_o == wr_data_i));

  a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en_i) && !wr_en_i && rd_b_idx_i == $past(wr_idx_i) && cwp_o == $past(cwp_o))
      |-> (rd_b_data_o == $past(wr_data_i)));
endmodule

bind rwin_regfile rwin_regfile_chk #(.NWIN(NWIN), .DW(DW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .call_i        (call_i),
  .ret_i         (ret_i),
  .win_invalid_i (win_invalid_i),
  .wr_en_i       (wr_en_i),
  .wr_idx_i      (wr_idx_i),
  .wr_data_i     (wr_data_i),
  .rd_a_idx_i    (rd_a_idx_i),
  .rd_a_data_o   (rd_a_data_o),
  .rd_b_idx_i    (rd_b_idx_i),
  .rd_b_data_o   (rd_b_data_o),
  .cwp_o         (cwp_o),
  .overflow_o    (overflow_o),
  .underflow_o   (underflow_o)
);

// File: tb/rwin_regfile_bench.sv
module rwin_regfile_bench;
  localparam int NW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        call_i = 1'b0, ret_i = 1'b0, wr_en_i = 1'b0;
  logic [NW-1:0] win_invalid_i = '0;
  logic [4:0]  wr_idx_i = '0, rd_a_idx_i = '0, rd_b_idx_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_a_data_o, rd_b_data_o;
  logic [2:0]  cwp_o;
  logic        overflow_o, underflow_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // behavioural model: shared globals, per-window argument and local banks
  logic [31:0] m_glob [8];
  logic [31:0] m_arg  [NW][8];
  logic [31:0] m_loc  [NW][8];
  int          m_win = 0;
  int unsigned seed = 32'h1d2c3b4a;

  always #4 clk = ~clk;

  rwin_regfile #(.NWIN(NW), .DW(32)) u_rwin_regfile (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
    .win_invalid_i(win_invalid_i), .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i),
    .wr_data_i(wr_data_i), .rd_a_idx_i(rd_a_idx_i), .rd_a_data_o(rd_a_data_o),
    .rd_b_idx_i(rd_b_idx_i), .rd_b_data_o(rd_b_data_o), .cwp_o(cwp_o),
    .overflow_o(overflow_o), .underflow_o(underflow_o)
  );

  function automatic logic [31:0] m_read(input int idx);
    if (wr_en_i && int'(wr_idx_i) == idx) return wr_data_i;
    if (idx < 8)  return m_glob[idx];
    if (idx < 16) return m_arg[m_win][idx-8];
    if (idx < 24) return m_loc[m_win][idx-16];
    return m_arg[(m_win + NW - 1) % NW][idx-24];
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit c, input bit r, input bit w, input int wi,
                      input logic [31:0] wd, input int ra, input int rb, input string tag);
    bit eo, eu;
    int tgt;
    call_i = c; ret_i = r; wr_en_i = w;
    wr_idx_i = 5'(wi); wr_data_i = wd; rd_a_idx_i = 5'(ra); rd_b_idx_i = 5'(rb);
    #1;
    eo = c && !r && win_invalid_i[(m_win + 1) % NW];
    eu = r && !c && win_invalid_i[(m_win + NW - 1) % NW];
    chk(tag, "rd_a", rd_a_data_o, m_read(ra));
    chk(tag, "rd_b", rd_b_data_o, m_read(rb));
    chk(tag, "overflow", 32'(overflow_o), 32'(eo));
    chk(tag, "underflow", 32'(underflow_o), 32'(eu));
    chk(tag, "cwp", 32'(cwp_o), 32'(m_win));
    @(posedge clk);
    if (w) begin
      if (wi < 8)       m_glob[wi] = wd;
      else if (wi < 16) m_arg[m_win][wi-8] = wd;
      else if (wi < 24) m_loc[m_win][wi-16] = wd;
      else              m_arg[(m_win + NW - 1) % NW][wi-24] = wd;
    end
    tgt = m_win;
    if (c && !r && !eo) tgt = (m_win + 1) % NW;
    if (r && !c && !eu) tgt = (m_win + NW - 1) % NW;
    m_win = tgt;
    @(negedge clk);
  endtask

  function automatic int unsigned rnd();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return seed;
  endfunction

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m_glob[i] = '0;
    for (int w = 0; w < NW; w++)
      for (int i = 0; i < 8; i++) begin m_arg[w][i] = '0; m_loc[w][i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset contents and pointer
    for (int i = 0; i < 32; i += 2) step(0, 0, 0, 0, 0, i, i + 1, "R1 reset state");

    // R9: write-through and later visibility in window 0
    for (int i = 0; i < 24; i++) step(0, 0, 1, i, 32'hA000_0000 + 32'(i), i, 0, "R9 write-through");
    for (int i = 0; i < 24; i += 2) step(0, 0, 0, 0, 0, i, i + 1, "R9 write landed");

    // R10: write a local together with the call; R4 pointer advance
    step(1, 0, 1, 20, 32'hC0DE_0014, 20, 3, "R10 write with call");
    // R5: callee sees caller's outgoing group as incoming
    for (int k = 0; k < 8; k += 2) step(0, 0, 0, 0, 0, 24 + k, 25 + k, "R5 callee reads args");
    // R2: globals shared; R3: callee locals private
    step(0, 0, 0, 0, 0, 1, 16, "R2 R3 global and private local");
    step(0, 0, 1, 24, 32'hBEEF_0018, 8, 17, "R3 callee outgoing empty");
    step(0, 0, 1, 16, 32'h1111_1111, 3, 24, "R2 R3 callee writes");
    step(1, 1, 0, 0, 0, 24, 16, "R8 call and return together");
    step(0, 1, 1, 25, 32'hBEEF_0019, 25, 1, "R10 write with return");
    step(0, 0, 0, 0, 0, 8, 9, "R5 caller sees callee results");
    step(0, 0, 0, 0, 0, 20, 16, "R10 R3 caller locals");

    // R4: full wrap forward and backward
    for (int i = 0; i < 9; i++) step(1, 0, 1, 16, 32'h5000_0000 + 32'(i), 16, 24, "R4 call wrap");
    for (int i = 0; i < 9; i++) step(0, 1, 0, 0, 0, 16, 8, "R4 return wrap");

    // R6 / R7: spilled targets block the move
    win_invalid_i = 8'h01 << ((m_win + 1) % NW);
    step(1, 0, 0, 0, 0, 8, 16, "R6 overflow");
    step(1, 0, 1, 9, 32'h0F0F_0F0F, 9, 16, "R6 overflow repeat");
    win_invalid_i = 8'h01 << ((m_win + NW - 1) % NW);
    step(0, 1, 0, 0, 0, 9, 24, "R7 underflow");
    step(1, 0, 0, 0, 0, 9, 24, "R7 call still free");
    step(0, 0, 0, 0, 0, 24, 25, "R11 idle quiet");
    win_invalid_i = '0;

    // mixed pseudo-random traffic, R11 idle cycles included
    for (int n = 0; n < 400; n++) begin
      int unsigned v;
      v = rnd();
      if (v[3:0] == 4'd0) win_invalid_i = 8'(rnd());
      step(v[4] & v[5], v[6] & v[7], v[8], int'(v[13:9]), rnd(), int'(v[18:14]),
           int'(v[23:19]), "R11 R4 R9 mixed");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule